// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides how a 32-bit CPU enters a handler. A pending exception code, an interrupt request, or both may be present. When the core raises a one-cycle accept strobe, the sequencer first resolves priority and masking. It then computes the saved copies of the status register, the program counter and general register 15, the event code, the new status word and the handler address. All of these results are registered together on the next clock edge.

The block offers the current interrupt mask level to an external interrupt controller. The controller answers with a vector and a valid flag. The sequencer does not fetch instructions and does not flush the pipeline. In the cycle that it raises `done`, it tells the core to drop its delay-slot flags and its wake-from-halt flag through two pulses.

Top module: `exc_entry_seq`

## Requirements
- R1: A pending exception wins over an interrupt request. When both are present at accept, the exception is taken, `expevt` gets the code and `intevt` keeps its old value.
- R2: When the block bit (status bit 28) is set, a pending exception with any code other than 0x1E0 is recorded as code 0x000 and treated as a reset-class entry. Code 0x1E0 is kept and goes to `vbr_in`+0x100.
- R3: When the block bit is set and only an interrupt is pending, the request is ignored unless `halt_wake` is high. When an entry is taken with the block bit and `halt_wake` both set, `wake_clr` pulses together with `done`.
- R4: `ic_level` always equals status bits 7:4. If an accepted interrupt finds `ic_vec_valid` low, no output changes and `done` stays low.
- R5: On every entry, `ssr` gets `sr_in`, `sgr` gets `r15_in`, and `sr_new` is `sr_in` with bits 28 (block), 29 (bank) and 30 (privileged) set.
- R6: When `in_ds` is high, the saved PC is `pc_in`-2 and `ds_clr` pulses with `done`. Otherwise the saved PC is `pc_in`.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, force status bits 7:4 to 0xF in `sr_new`, and set `pc_new` to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set `pc_new` to `vbr_in`+0x400.
- R9: Code 0x160 adds 2 to the saved PC, after any delay-slot correction. Code 0x160 and every exception code not named in R7 or R8 go to `vbr_in`+0x100.
- R10: A taken interrupt writes `ic_vec` into `intevt`, leaves `expevt` unchanged and sets `pc_new` to `vbr_in`+0x600.
- R11: All outputs change only on the edge that follows an accept cycle. `done` is high for exactly that one cycle. Without accept, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept | input | 1 | One-cycle strobe: evaluate and enter now |
| exc_pending | input | 1 | An exception code is pending |
| exc_code | input | 12 | Pending exception code |
| irq_req | input | 1 | Interrupt request present |
| halt_wake | input | 1 | Core is waking from a halt |
| in_ds | input | 1 | Faulting instruction sits in a delay slot |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current PC |
| r15_in | input | 32 | Current general register 15 |
| vbr_in | input | 32 | Vector base |
| ic_level | output | 4 | Mask level offered to the interrupt controller |
| ic_vec_valid | input | 1 | Controller has an eligible vector |
| ic_vec | input | 12 | Vector from the controller |
| done | output | 1 | Entry performed in this cycle |
| ssr | output | 32 | Saved status |
| spc | output | 32 | Saved PC |
| sgr | output | 32 | Saved register 15 |
| expevt | output | 12 | Last exception code |
| intevt | output | 12 | Last interrupt vector |
| sr_new | output | 32 | Status word for the handler |
| pc_new | output | 32 | Handler address |
| ds_clr | output | 1 | Core must clear its delay-slot flags |
| wake_clr | output | 1 | Core must clear its wake-from-halt flag |

## Verification
The bench targets the corners where entry goes subtly wrong.

- Exception and interrupt together: a design that let the interrupt win would overwrite `intevt` and jump to the +0x600 offset.
- Block bit: a design that missed the forced reset would go to the general vector with the original code. One that also forced 0x1E0 would lose that code.
- Masked interrupt without wake, and interrupt with no vector: a faulty design would raise `done` and corrupt the saved registers.
- Trap instruction in a delay slot: this checks that the two PC corrections cancel.
- Reset-class codes with the FD bit set and a low mask: these expose a handler status word that forgets to clear FD or to raise the mask.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
    // status register bit positions
    localparam int SR_BL_BIT  = 28;
    localparam int SR_RB_BIT  = 29;
    localparam int SR_MD_BIT  = 30;
    localparam int SR_FD_BIT  = 15;
    localparam int SR_IM_LSB  = 4;
    localparam int SR_IM_W    = 4;

    // event codes with special handling
    localparam logic [11:0] EV_RESET    = 12'h000;
    localparam logic [11:0] EV_MRESET   = 12'h020;
    localparam logic [11:0] EV_MULTIHIT = 12'h140;
    localparam logic [11:0] EV_RMISS    = 12'h040;
    localparam logic [11:0] EV_WMISS    = 12'h060;
    localparam logic [11:0] EV_TRAP     = 12'h160;
    localparam logic [11:0] EV_KEEP_BL  = 12'h1E0;

    // handler addresses
    localparam logic [31:0] RESET_PC    = 32'hA000_0000;
    localparam logic [31:0] OFS_GENERAL = 32'h0000_0100;
    localparam logic [31:0] OFS_TLBMISS = 32'h0000_0400;
    localparam logic [31:0] OFS_IRQ     = 32'h0000_0600;

    typedef enum logic [1:0] {
        RT_RESET   = 2'd0,
        RT_TLBMISS = 2'd1,
        RT_GENERAL = 2'd2,
        RT_IRQ     = 2'd3
    } route_e;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              blocked,
    input  logic              halt_wake,
    input  logic              ic_vec_valid,
    input  logic [CODE_W-1:0] ic_vec,
    output logic              take,
    output logic              is_irq,
    output logic [CODE_W-1:0] eff_code,
    output logic              wake_used
);
    localparam logic [CODE_W-1:0] KEEP_CODE  = CODE_W'(EV_KEEP_BL);
    localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(EV_RESET);

    always_comb begin
        take     = 1'b0;
        is_irq   = 1'b0;
        eff_code = exc_code;
        if (exc_pending) begin
            take = 1'b1;
            if (blocked && (exc_code != KEEP_CODE)) begin
                eff_code = RESET_CODE;
            end
        end else if (irq_req) begin
            is_irq   = 1'b1;
            eff_code = ic_vec;
            take     = ic_vec_valid && (!blocked || halt_wake);
        end
        wake_used = take && blocked && halt_wake;
    end
endmodule

// File: rtl/exc_route.sv
`timescale 1ns/1ps
module exc_route
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   vbr,
    output route_e            route,
    output logic              is_trap,
    output logic [XLEN-1:0]   target
);
    always_comb begin
        is_trap = 1'b0;
        if (is_irq) begin
            route = RT_IRQ;
        end else begin
            unique case (code)
                CODE_W'(EV_RESET),
                CODE_W'(EV_MRESET),
                CODE_W'(EV_MULTIHIT): route = RT_RESET;
                CODE_W'(EV_RMISS),
                CODE_W'(EV_WMISS):    route = RT_TLBMISS;
                default:              route = RT_GENERAL;
            endcase
            is_trap = (code == CODE_W'(EV_TRAP));
        end
        unique case (route)
            RT_RESET:   target = XLEN'(RESET_PC);
            RT_TLBMISS: target = vbr + XLEN'(OFS_TLBMISS);
            RT_IRQ:     target = vbr + XLEN'(OFS_IRQ);
            default:    target = vbr + XLEN'(OFS_GENERAL);
        endcase
    end
endmodule

// File: rtl/exc_save_pc.sv
`timescale 1ns/1ps
module exc_save_pc #(
    parameter int XLEN  = 32,
    parameter int ISIZE = 2
) (
    input  logic [XLEN-1:0] pc,
    input  logic            in_ds,
    input  logic            is_trap,
    output logic [XLEN-1:0] saved
);
    localparam logic [XLEN-1:0] STEP = XLEN'(ISIZE);
    logic [XLEN-1:0] after_ds;

    always_comb begin
        after_ds = in_ds   ? (pc - STEP)       : pc;
        saved    = is_trap ? (after_ds + STEP) : after_ds;
    end
endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              exc_pending,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              halt_wake,
    input  logic              in_ds,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic [SR_IM_W-1:0] ic_level,
    input  logic              ic_vec_valid,
    input  logic [CODE_W-1:0] ic_vec,
    output logic              done,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   sgr,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic [XLEN-1:0]   sr_new,
    output logic [XLEN-1:0]   pc_new,
    output logic              ds_clr,
    output logic              wake_clr
);
    typedef struct packed {
        logic [XLEN-1:0]   ssr;
        logic [XLEN-1:0]   spc;
        logic [XLEN-1:0]   sgr;
        logic [CODE_W-1:0] expevt;
        logic [CODE_W-1:0] intevt;
        logic [XLEN-1:0]   sr;
        logic [XLEN-1:0]   pc;
        logic              done;
        logic              ds_clr;
        logic              wake_clr;
    } state_t;

    state_t st_d, st_q;

    logic              take, is_irq, wake_used, is_trap;
    logic [CODE_W-1:0] eff_code;
    route_e            route;
    logic [XLEN-1:0]   target, saved_pc;

    assign ic_level = sr_in[SR_IM_LSB +: SR_IM_W];

    exc_arbiter #(.CODE_W(CODE_W)) u_arb (
        .exc_pending (exc_pending),
        .exc_code    (exc_code),
        .irq_req     (irq_req),
        .blocked     (sr_in[SR_BL_BIT]),
        .halt_wake   (halt_wake),
        .ic_vec_valid(ic_vec_valid),
        .ic_vec      (ic_vec),
        .take        (take),
        .is_irq      (is_irq),
        .eff_code    (eff_code),
        .wake_used   (wake_used)
    );

    exc_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
        .is_irq (is_irq),
        .code   (eff_code),
        .vbr    (vbr_in),
        .route  (route),
        .is_trap(is_trap),
        .target (target)
    );

    exc_save_pc #(.XLEN(XLEN), .ISIZE(2)) u_spc (
        .pc     (pc_in),
        .in_ds  (in_ds),
        .is_trap(is_trap),
        .saved  (saved_pc)
    );

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.ds_clr   = 1'b0;
        st_d.wake_clr = 1'b0;
        if (accept && take) begin
            st_d.ssr = sr_in;
            st_d.spc = saved_pc;
            st_d.sgr = r15_in;
            if (is_irq) begin
                st_d.intevt = eff_code;
            end else begin
                st_d.expevt = eff_code;
            end
            st_d.sr              = sr_in;
            st_d.sr[SR_BL_BIT]   = 1'b1;
            st_d.sr[SR_RB_BIT]   = 1'b1;
            st_d.sr[SR_MD_BIT]   = 1'b1;
            if (route == RT_RESET) begin
                st_d.sr[SR_FD_BIT]                = 1'b0;
                st_d.sr[SR_IM_LSB +: SR_IM_W]     = '1;
            end
            st_d.pc       = target;
            st_d.done     = 1'b1;
            st_d.ds_clr   = in_ds;
            st_d.wake_clr = wake_used;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done     = st_q.done;
    assign ssr      = st_q.ssr;
    assign spc      = st_q.spc;
    assign sgr      = st_q.sgr;
    assign expevt   = st_q.expevt;
    assign intevt   = st_q.intevt;
    assign sr_new   = st_q.sr;
    assign pc_new   = st_q.pc;
    assign ds_clr   = st_q.ds_clr;
    assign wake_clr = st_q.wake_clr;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              exc_pending,
    input logic              irq_req,
    input logic              ic_vec_valid,
    input logic [XLEN-1:0]   vbr_in,
    input logic              done,
    input logic              ds_clr,
    input logic              wake_clr,
    input logic [XLEN-1:0]   sr_new,
    input logic [XLEN-1:0]   pc_new,
    input logic [XLEN-1:0]   ssr,
    input logic [XLEN-1:0]   spc,
    input logic [XLEN-1:0]   sgr,
    input logic [CODE_W-1:0] intevt
);
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept)); // R11
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ssr) && $stable(spc) && $stable(sgr) && $stable(pc_new) && $stable(sr_new))); // R11
    AST_SR_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sr_new[28] && sr_new[29] && sr_new[30])); // R5
    AST_NO_VECTOR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !exc_pending && irq_req && !ic_vec_valid) |=> !done); // R4
    AST_EXC_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && exc_pending && irq_req) |=> (done && $stable(intevt))); // R1
    AST_IRQ_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!exc_pending && irq_req)) |-> (pc_new == $past(vbr_in) + 32'h600)); // R10
    AST_WAKE_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr |-> done); // R3
    AST_DS_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ds_clr |-> done); // R6
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .exc_pending (exc_pending),
    .irq_req     (irq_req),
    .ic_vec_valid(ic_vec_valid),
    .vbr_in      (vbr_in),
    .done        (done),
    .ds_clr      (ds_clr),
    .wake_clr    (wake_clr),
    .sr_new      (sr_new),
    .pc_new      (pc_new),
    .ssr         (ssr),
    .spc         (spc),
    .sgr         (sgr),
    .intevt      (intevt)
);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        accept = 1'b0;
    logic        exc_pending = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic        halt_wake = 1'b0;
    logic        in_ds = 1'b0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic [3:0]  ic_level;
    logic        ic_vec_valid = 1'b0;
    logic [11:0] ic_vec = '0;
    logic        done, ds_clr, wake_clr;
    logic [31:0] ssr, spc, sgr, sr_new, pc_new;
    logic [11:0] expevt, intevt;

    always #2.5 clk = ~clk;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .accept(accept), .exc_pending(exc_pending),
        .exc_code(exc_code), .irq_req(irq_req), .halt_wake(halt_wake), .in_ds(in_ds),
        .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in),
        .ic_level(ic_level), .ic_vec_valid(ic_vec_valid), .ic_vec(ic_vec),
        .done(done), .ssr(ssr), .spc(spc), .sgr(sgr), .expevt(expevt),
        .intevt(intevt), .sr_new(sr_new), .pc_new(pc_new), .ds_clr(ds_clr),
        .wake_clr(wake_clr)
    );

    typedef struct {
        string       tag;
        logic        done;
        logic [31:0] ssr, spc, sgr, sr, pc;
        logic [11:0] expevt, intevt;
        logic        dsc, wkc;
    } item_t;

    item_t q[$];
    item_t model;
    int vectors = 0;
    int misses = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compares outputs one cycle after each accepted stimulus
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                chk(e.tag, "done",     {31'd0, done},     {31'd0, e.done});
                chk(e.tag, "ssr",      ssr,               e.ssr);
                chk(e.tag, "spc",      spc,               e.spc);
                chk(e.tag, "sgr",      sgr,               e.sgr);
                chk(e.tag, "expevt",   {20'd0, expevt},   {20'd0, e.expevt});
                chk(e.tag, "intevt",   {20'd0, intevt},   {20'd0, e.intevt});
                chk(e.tag, "sr_new",   sr_new,            e.sr);
                chk(e.tag, "pc_new",   pc_new,            e.pc);
                chk(e.tag, "ds_clr",   {31'd0, ds_clr},   {31'd0, e.dsc});
                chk(e.tag, "wake_clr", {31'd0, wake_clr}, {31'd0, e.wkc});
            end
        end
    end

    // driver: applies one stimulus and pushes the expected result
    task automatic apply(string tag, logic acc, logic ep, logic [11:0] code,
                         logic irq, logic vv, logic [11:0] vec, logic [31:0] sr,
                         logic [31:0] pc, logic [31:0] r15, logic [31:0] vbr,
                         logic ds, logic wake);
        logic bl, take, irqp;
        logic [11:0] c;
        item_t e;
        @(negedge clk);
        accept = acc; exc_pending = ep; exc_code = code; irq_req = irq;
        ic_vec_valid = vv; ic_vec = vec; sr_in = sr; pc_in = pc; r15_in = r15;
        vbr_in = vbr; in_ds = ds; halt_wake = wake;
        #1;
        chk(tag, "ic_level R4", {28'd0, ic_level}, {28'd0, sr[7:4]});
        bl = sr[28]; irqp = 1'b0; take = 1'b0; c = code;
        if (ep) begin
            take = 1'b1;
            if (bl && code != 12'h1E0) c = 12'h000;
        end else if (irq) begin
            irqp = 1'b1; c = vec;
            take = vv && (!bl || wake);
        end
        take = take && acc;
        e = model;
        e.tag = tag; e.done = 1'b0; e.dsc = 1'b0; e.wkc = 1'b0;
        if (take) begin
            e.done = 1'b1;
            e.ssr = sr; e.sgr = r15;
            e.spc = pc - (ds ? 32'd2 : 32'd0) + ((!irqp && c == 12'h160) ? 32'd2 : 32'd0);
            e.sr = sr | 32'h7000_0000;
            if (irqp) begin
                e.intevt = c; e.pc = vbr + 32'h600;
            end else begin
                e.expevt = c;
                if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
                    e.sr[15] = 1'b0; e.sr[7:4] = 4'hF; e.pc = 32'hA000_0000;
                end else if (c == 12'h040 || c == 12'h060) begin
                    e.pc = vbr + 32'h400;
                end else begin
                    e.pc = vbr + 32'h100;
                end
            end
            e.dsc = ds; e.wkc = bl && wake;
        end
        model = e;
        @(posedge clk);
        #1;
        q.push_back(e);
        @(negedge clk);
        accept = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        model = '{tag: "", done: 1'b0, ssr: '0, spc: '0, sgr: '0, sr: '0, pc: '0,
                  expevt: '0, intevt: '0, dsc: 1'b0, wkc: 1'b0};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset", "done",   {31'd0, done}, 32'd0);
        chk("R11 reset", "pc_new", pc_new, 32'd0);
        chk("R11 reset", "ssr",    ssr, 32'd0);
        //                tag                acc  ep   code   irq  vv   vec    sr            pc            r15           vbr           ds   wake
        apply("R8 read miss",   1, 1, 12'h040, 0, 0, 12'h000, 32'h0000_0030, 32'h0C00_1000, 32'h1111_0000, 32'h8C00_0000, 0, 0);
        apply("R8 write miss",  1, 1, 12'h060, 0, 0, 12'h000, 32'h4000_00F0, 32'h0C00_2002, 32'h2222_0000, 32'h8D00_0000, 0, 0);
        apply("R9 general",     1, 1, 12'h0A0, 0, 0, 12'h000, 32'h0000_0010, 32'h0C00_3000, 32'h3333_0000, 32'h8C00_0000, 0, 0);
        apply("R9 trap",        1, 1, 12'h160, 0, 0, 12'h000, 32'h0000_0000, 32'h0C00_4000, 32'h4444_0000, 32'h8C00_0000, 0, 0);
        apply("R9 R6 trap ds",  1, 1, 12'h160, 0, 0, 12'h000, 32'h0000_0000, 32'h0C00_5000, 32'h5555_0000, 32'h8C00_0000, 1, 0);
        apply("R6 ds general",  1, 1, 12'h180, 0, 0, 12'h000, 32'h0000_0000, 32'h0C00_6000, 32'h6666_0000, 32'h8C00_0000, 1, 0);
        apply("R7 code 020",    1, 1, 12'h020, 0, 0, 12'h000, 32'h0000_8030, 32'h0C00_7000, 32'h7777_0000, 32'h8C00_0000, 0, 0);
        apply("R7 code 140",    1, 1, 12'h140, 0, 0, 12'h000, 32'h0000_8050, 32'h0C00_7100, 32'h7777_1111, 32'h8C00_0000, 0, 0);
        apply("R1 both",        1, 1, 12'h0E0, 1, 1, 12'h5A0, 32'h0000_0000, 32'h0C00_8000, 32'h8888_0000, 32'h8E00_0000, 0, 0);
        apply("R10 interrupt",  1, 0, 12'h000, 1, 1, 12'h320, 32'h0000_0070, 32'h0C00_9000, 32'h9999_0000, 32'h8E00_0000, 0, 0);
        apply("R4 no vector",   1, 0, 12'h000, 1, 0, 12'h000, 32'h0000_0090, 32'h0C00_A000, 32'hAAAA_0000, 32'h8F00_0000, 0, 0);
        apply("R2 bl to reset", 1, 1, 12'h0A0, 0, 0, 12'h000, 32'h1000_8020, 32'h0C00_B000, 32'hBBBB_0000, 32'h8C00_0000, 0, 0);
        apply("R2 bl keep 1E0", 1, 1, 12'h1E0, 0, 0, 12'h000, 32'h1000_0000, 32'h0C00_C000, 32'hCCCC_0000, 32'h8C00_0000, 0, 0);
        apply("R3 bl irq mask", 1, 0, 12'h000, 1, 1, 12'h400, 32'h1000_0000, 32'h0C00_D000, 32'hDDDD_0000, 32'h8C00_0000, 0, 0);
        apply("R3 bl irq wake", 1, 0, 12'h000, 1, 1, 12'h420, 32'h1000_0000, 32'h0C00_E000, 32'hEEEE_0000, 32'h8C00_0000, 0, 1);
        apply("R11 no accept",  0, 1, 12'h040, 1, 1, 12'h440, 32'h0000_00A0, 32'h0C00_F000, 32'hFFFF_0000, 32'h8C00_0000, 1, 0);
        apply("R5 R10 irq ds",  1, 0, 12'h000, 1, 1, 12'h460, 32'h0000_0000, 32'h0C01_0000, 32'h0101_0101, 32'h9000_0000, 1, 0);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule